// File: doc/BRIEF.md
# Serial Byte Transmitter with Priority Special Characters

This block sends bytes on a single serial line with a fixed asynchronous frame: one low start bit, eight data bits with the least significant bit first, and one high stop bit. The line rests high between frames. Each bit lasts one period of an external `baud_tick` strobe, so the bit rate is set outside the block. Ordinary payload bytes are written into an internal queue and leave the line in the order they were written.

A host byte interface holds four programmable special characters and a command register. When the host writes a send command that names one of the four characters, that character jumps ahead of every byte still waiting in the queue. A frame already on the line always finishes first. The command is accepted at the next character boundary, and the command register then clears itself. A send command that names a reserved selection is dropped. The register clears and a one-cycle error strobe is raised. A status register shows whether a send command is still waiting to be accepted.

Top module: `serial_tx_inject`

## Requirements
- R1: After reset, `tx_out` is 1, `cmd_err` and `fifo_full` are 0, and reads of offsets 0 to 5 all return 0x00.
- R2: Each frame is one start bit at 0, then eight data bits with bit 0 first, then one stop bit at 1. Every bit holds for exactly one `baud_tick` period, and the line stays at 1 when nothing is being sent.
- R3: Queued bytes are sent in the order they were written. `fifo_full` is 1 while DEPTH bytes are waiting, and a write made while it is 1 is discarded.
- R4: Offsets 1, 2, 3 and 4 are byte read/write registers that hold special characters 1 to 4.
- R5: Offset 0 is the command register. Bit 3 is the send request, and bits 2:0 pick the character: 001 picks 1, 010 picks 2, 011 picks 3 and 100 picks 4. A valid send command transmits the chosen register's byte once.
- R6: A pending special character is sent before any queued byte that has not yet started, but only after the frame currently on the line has finished.
- R7: The command register reads back its written value until the command is accepted at a character boundary. After that it reads 0x00.
- R8: A command with bit 3 set and select 000, 101, 110 or 111 sends nothing. The register reads 0x00 on the next read, and `cmd_err` is 1 for exactly one cycle.
- R9: Bit 0 of offset 5 reads 1 while a valid send command waits to be accepted. It reads 0 otherwise, and the other bits of offset 5 read 0.
- R10: A write to offset 0 with bit 3 clear is stored and reads back unchanged. It sends nothing and does not make bit 0 of offset 5 read 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| baud_tick | input | 1 | One-cycle strobe marking each bit period |
| host_wr | input | 1 | Host register write strobe |
| host_addr | input | ADDR_W | Host register offset |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Registered read data for the offset of the previous cycle |
| fifo_wr | input | 1 | Payload queue write strobe |
| fifo_wdata | input | 8 | Payload byte |
| fifo_full | output | 1 | Queue holds DEPTH bytes |
| tx_out | output | 1 | Serial line, idle high |
| cmd_err | output | 1 | One-cycle strobe for a rejected send command |

## Verification
A wrong choice by the boundary arbiter appears as a wrong byte in the next decoded frame. The bench sees it within one frame time, ten baud periods after the boundary. A command register that fails to clear, or clears too early, shows up two cycles later on a read of offset 0 or of the pending bit at offset 5. It is also seen as a repeated or missing special character in the next frame. Bit-timing faults change the measured width of the start bit, and queue pointer faults scramble or drop bytes in the burst that fills the queue.

// File: rtl/txi_pkg.sv
package txi_pkg;
  localparam int unsigned BYTE_W       = 8;
  localparam int unsigned DATA_BITS    = 8;
  localparam int unsigned NUM_SPC      = 4;
  localparam int unsigned CMD_SEND_BIT = 3;
  localparam int unsigned ADR_CMD      = 0;
  localparam int unsigned ADR_SPC0     = 1;
  localparam int unsigned ADR_STAT     = 5;

  typedef logic [BYTE_W-1:0] byte_t;

  typedef enum logic [1:0] {
    SH_IDLE,
    SH_START,
    SH_DATA,
    SH_STOP
  } sh_state_e;
endpackage

// File: rtl/txi_fifo.sv
module txi_fifo #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             rd_en,
  output logic [WIDTH-1:0] head,
  output logic             avail,
  output logic             full
);
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);
  localparam logic [CNT_W-1:0] CNT_MAX  = CNT_W'(DEPTH);
  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);

  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [PTR_W-1:0] wr_ptr_q, rd_ptr_q;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             push, pop;

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    return (p == PTR_LAST) ? '0 : p + 1'b1;
  endfunction

  assign push = wr_en && (cnt_q != CNT_MAX);
  assign pop  = rd_en && (cnt_q != '0);

  always_comb begin
    cnt_d = cnt_q;
    if (push && !pop) cnt_d = cnt_q + 1'b1;
    else if (pop && !push) cnt_d = cnt_q - 1'b1;
  end

  // storage without reset, registered read: block RAM friendly
  always_ff @(posedge clk) begin
    if (push) mem_q[wr_ptr_q] <= wr_data;
    head <= mem_q[rd_ptr_q];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
      avail    <= 1'b0;
      full     <= 1'b0;
    end else begin
      if (push) wr_ptr_q <= ptr_inc(wr_ptr_q);
      if (pop)  rd_ptr_q <= ptr_inc(rd_ptr_q);
      cnt_q <= cnt_d;
      // lags the count by one cycle so head has been refreshed
      avail <= (cnt_q != '0);
      full  <= (cnt_d == CNT_MAX);
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst) cnt_q <= CNT_MAX); // R3
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst) rd_en |-> (cnt_q != '0)); // R3
  AST_FULL_BLOCKS: assert property (@(posedge clk) disable iff (rst) (full && wr_en && !rd_en) |=> $stable(wr_ptr_q)); // R3
endmodule

// File: rtl/txi_regs.sv
module txi_regs
  import txi_pkg::*;
#(
  parameter int unsigned ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_wr,
  input  logic [ADDR_W-1:0] host_addr,
  input  byte_t             host_wdata,
  output byte_t             host_rdata,
  input  logic              spc_take,
  output logic              spc_req,
  output byte_t             spc_byte,
  output logic              err_pulse
);
  localparam int unsigned SEL_W = $clog2(NUM_SPC + 1);

  byte_t            cmd_q;
  byte_t            spc_q [NUM_SPC];
  logic             wr_cmd, bad_wr;
  logic [SEL_W-1:0] sel;

  function automatic logic sel_ok(input logic [SEL_W-1:0] c);
    return (c != '0) && (c <= SEL_W'(NUM_SPC));
  endfunction

  assign wr_cmd = host_wr && (host_addr == ADDR_W'(ADR_CMD));
  assign bad_wr = wr_cmd && host_wdata[CMD_SEND_BIT] && !sel_ok(host_wdata[SEL_W-1:0]);
  assign sel    = cmd_q[SEL_W-1:0];
  // only valid selections are ever stored with the send bit set
  assign spc_req = cmd_q[CMD_SEND_BIT];

  always_comb begin
    spc_byte = '0;
    for (int i = 0; i < NUM_SPC; i++) begin
      if (sel == SEL_W'(i + 1)) spc_byte = spc_q[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_q     <= '0;
      err_pulse <= 1'b0;
    end else begin
      err_pulse <= bad_wr;
      if (wr_cmd)        cmd_q <= bad_wr ? '0 : host_wdata;
      else if (spc_take) cmd_q <= '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_SPC; i++) spc_q[i] <= '0;
    end else if (host_wr) begin
      for (int i = 0; i < NUM_SPC; i++) begin
        if (host_addr == ADDR_W'(ADR_SPC0 + i)) spc_q[i] <= host_wdata;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      host_rdata <= '0;
    end else begin
      host_rdata <= '0;
      if (host_addr == ADDR_W'(ADR_CMD)) host_rdata <= cmd_q;
      if (host_addr == ADDR_W'(ADR_STAT)) host_rdata <= {{(BYTE_W-1){1'b0}}, cmd_q[CMD_SEND_BIT]};
      for (int i = 0; i < NUM_SPC; i++) begin
        if (host_addr == ADDR_W'(ADR_SPC0 + i)) host_rdata <= spc_q[i];
      end
    end
  end

  AST_CMD_CLEARS: assert property (@(posedge clk) disable iff (rst) (spc_take && !wr_cmd) |=> (cmd_q == '0)); // R7
  AST_ERR_NO_SEND: assert property (@(posedge clk) disable iff (rst) err_pulse |-> !spc_req); // R8
  AST_PEND_HOLDS: assert property (@(posedge clk) disable iff (rst) (spc_req && !spc_take && !host_wr) |=> spc_req); // R7
endmodule

// File: rtl/txi_shifter.sv
module txi_shifter
  import txi_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  baud_tick,
  input  logic  spc_req,
  input  byte_t spc_byte,
  input  logic  fifo_avail,
  input  byte_t fifo_byte,
  output logic  spc_take,
  output logic  fifo_pop,
  output logic  tx
);
  localparam int unsigned BIT_W = $clog2(DATA_BITS);
  localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(DATA_BITS - 1);

  sh_state_e        st_q;
  byte_t            sr_q;
  logic [BIT_W-1:0] bit_q;
  logic             at_bound, load;

  // a character boundary is an idle tick or the tick that ends a stop bit
  assign at_bound = baud_tick && ((st_q == SH_IDLE) || (st_q == SH_STOP));
  assign spc_take = at_bound && spc_req;
  assign fifo_pop = at_bound && !spc_req && fifo_avail;
  assign load     = spc_take || fifo_pop;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= SH_IDLE;
      sr_q  <= '0;
      bit_q <= '0;
      tx    <= 1'b1;
    end else if (baud_tick) begin
      case (st_q)
        SH_IDLE, SH_STOP: begin
          if (load) begin
            sr_q <= spc_take ? spc_byte : fifo_byte;
            tx   <= 1'b0;
            st_q <= SH_START;
          end else begin
            tx   <= 1'b1;
            st_q <= SH_IDLE;
          end
        end
        SH_START: begin
          tx    <= sr_q[0];
          sr_q  <= sr_q >> 1;
          bit_q <= '0;
          st_q  <= SH_DATA;
        end
        SH_DATA: begin
          if (bit_q == BIT_LAST) begin
            tx   <= 1'b1;
            st_q <= SH_STOP;
          end else begin
            tx    <= sr_q[0];
            sr_q  <= sr_q >> 1;
            bit_q <= bit_q + 1'b1;
          end
        end
        default: begin
          tx   <= 1'b1;
          st_q <= SH_IDLE;
        end
      endcase
    end
  end

  AST_START_LOW: assert property (@(posedge clk) disable iff (rst) load |=> !tx); // R2
  AST_STOP_HIGH: assert property (@(posedge clk) disable iff (rst) (st_q == SH_STOP) |-> tx); // R2
  AST_HOLD_BETWEEN_TICKS: assert property (@(posedge clk) disable iff (rst) !baud_tick |=> $stable(tx)); // R2
endmodule

// File: rtl/serial_tx_inject.sv
module serial_tx_inject
  import txi_pkg::*;
#(
  parameter int unsigned ADDR_W = 3,
  parameter int unsigned DEPTH  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              baud_tick,
  input  logic              host_wr,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [7:0]        host_wdata,
  output logic [7:0]        host_rdata,
  input  logic              fifo_wr,
  input  logic [7:0]        fifo_wdata,
  output logic              fifo_full,
  output logic              tx_out,
  output logic              cmd_err
);
  byte_t head_byte, spc_byte;
  logic  head_avail, fifo_pop, spc_req, spc_take;

  txi_fifo #(.DEPTH(DEPTH), .WIDTH(BYTE_W)) u_fifo (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (fifo_wr),
    .wr_data (fifo_wdata),
    .rd_en   (fifo_pop),
    .head    (head_byte),
    .avail   (head_avail),
    .full    (fifo_full)
  );

  txi_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk        (clk),
    .rst        (rst),
    .host_wr    (host_wr),
    .host_addr  (host_addr),
    .host_wdata (host_wdata),
    .host_rdata (host_rdata),
    .spc_take   (spc_take),
    .spc_req    (spc_req),
    .spc_byte   (spc_byte),
    .err_pulse  (cmd_err)
  );

  txi_shifter u_shift (
    .clk        (clk),
    .rst        (rst),
    .baud_tick  (baud_tick),
    .spc_req    (spc_req),
    .spc_byte   (spc_byte),
    .fifo_avail (head_avail),
    .fifo_byte  (head_byte),
    .spc_take   (spc_take),
    .fifo_pop   (fifo_pop),
    .tx         (tx_out)
  );

  AST_SPC_BEFORE_FIFO: assert property (@(posedge clk) disable iff (rst) fifo_pop |-> !spc_req); // R6
  AST_TAKE_ON_TICK: assert property (@(posedge clk) disable iff (rst) (spc_take || fifo_pop) |-> baud_tick); // R6
endmodule

// File: tb/test_serial_tx_inject.sv
module test_serial_tx_inject;
  localparam int CLK_PERIOD = 10;
  localparam int TICK_DIV   = 4;
  localparam int DEPTH      = 16;

  localparam logic [2:0] OP_WR   = 3'd0;
  localparam logic [2:0] OP_PUSH = 3'd1;
  localparam logic [2:0] OP_RD   = 3'd2;
  localparam logic [2:0] OP_EXPB = 3'd3;
  localparam logic [2:0] OP_WAIT = 3'd4;
  localparam logic [2:0] OP_ERRC = 3'd5;

  // {op, addr, data, requirement number}
  localparam int NV = 41;
  localparam logic [17:0] VEC [NV] = '{
    {OP_WR,   3'd1, 8'hA5, 4'd4},   // R4 special 1
    {OP_WR,   3'd2, 8'h3C, 4'd4},   // R4 special 2
    {OP_WR,   3'd3, 8'h81, 4'd4},   // R4 special 3
    {OP_WR,   3'd4, 8'h7E, 4'd4},   // R4 special 4
    {OP_RD,   3'd1, 8'hA5, 4'd4},   // R4
    {OP_RD,   3'd2, 8'h3C, 4'd4},   // R4
    {OP_RD,   3'd4, 8'h7E, 4'd4},   // R4
    {OP_PUSH, 3'd0, 8'h11, 4'd3},   // R3
    {OP_PUSH, 3'd0, 8'h22, 4'd3},   // R3
    {OP_PUSH, 3'd0, 8'h33, 4'd3},   // R3
    {OP_EXPB, 3'd0, 8'h11, 4'd2},   // R2 frame decode
    {OP_WAIT, 3'd0, 8'd10, 4'd6},   // R6 let 0x22 start
    {OP_WR,   3'd0, 8'h0A, 4'd5},   // R5 send special 2
    {OP_RD,   3'd0, 8'h0A, 4'd7},   // R7 still pending
    {OP_RD,   3'd5, 8'h01, 4'd9},   // R9 pending flag
    {OP_EXPB, 3'd0, 8'h22, 4'd6},   // R6 frame in flight finishes
    {OP_EXPB, 3'd0, 8'h3C, 4'd6},   // R6 special ahead of 0x33
    {OP_RD,   3'd0, 8'h00, 4'd7},   // R7 self-cleared
    {OP_RD,   3'd5, 8'h00, 4'd9},   // R9
    {OP_EXPB, 3'd0, 8'h33, 4'd3},   // R3
    {OP_WR,   3'd0, 8'h09, 4'd5},   // R5 special 1
    {OP_EXPB, 3'd0, 8'hA5, 4'd5},   // R5
    {OP_WR,   3'd0, 8'h0C, 4'd5},   // R5 special 4
    {OP_EXPB, 3'd0, 8'h7E, 4'd5},   // R5
    {OP_WR,   3'd0, 8'h0B, 4'd5},   // R5 special 3
    {OP_EXPB, 3'd0, 8'h81, 4'd5},   // R5
    {OP_WR,   3'd0, 8'h08, 4'd8},   // R8 select 000
    {OP_ERRC, 3'd0, 8'd1,  4'd8},   // R8
    {OP_RD,   3'd0, 8'h00, 4'd8},   // R8
    {OP_WR,   3'd0, 8'h0D, 4'd8},   // R8 select 101
    {OP_WR,   3'd0, 8'h0E, 4'd8},   // R8 select 110
    {OP_WR,   3'd0, 8'h0F, 4'd8},   // R8 select 111
    {OP_ERRC, 3'd0, 8'd4,  4'd8},   // R8
    {OP_RD,   3'd5, 8'h00, 4'd8},   // R8
    {OP_WR,   3'd0, 8'h02, 4'd10},  // R10 no send bit
    {OP_RD,   3'd0, 8'h02, 4'd10},  // R10
    {OP_RD,   3'd5, 8'h00, 4'd10},  // R10
    {OP_WAIT, 3'd0, 8'd96, 4'd10},  // R10 nothing should go out
    {OP_PUSH, 3'd0, 8'h55, 4'd10},  // R10
    {OP_EXPB, 3'd0, 8'h55, 4'd10},  // R8 R10 next frame is the payload
    {OP_WR,   3'd0, 8'h00, 4'd10}   // R10
  };

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       baud_tick = 1'b0;
  logic       host_wr = 1'b0;
  logic [2:0] host_addr = '0;
  logic [7:0] host_wdata = '0;
  logic [7:0] host_rdata;
  logic       fifo_wr = 1'b0;
  logic [7:0] fifo_wdata = '0;
  logic       fifo_full;
  logic       tx_out;
  logic       cmd_err;

  int n_checks = 0;
  int n_fail   = 0;
  int err_cnt  = 0;
  bit tick_en  = 1'b0;
  logic [7:0] rx_buf [64];
  int rx_wr = 0;
  int rx_rd = 0;

  serial_tx_inject #(.ADDR_W(3), .DEPTH(DEPTH)) i_serial_tx_inject (
    .clk        (clk),
    .rst        (rst),
    .baud_tick  (baud_tick),
    .host_wr    (host_wr),
    .host_addr  (host_addr),
    .host_wdata (host_wdata),
    .host_rdata (host_rdata),
    .fifo_wr    (fifo_wr),
    .fifo_wdata (fifo_wdata),
    .fifo_full  (fifo_full),
    .tx_out     (tx_out),
    .cmd_err    (cmd_err)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // tick generator, error-strobe counter and line decoder in one process
  initial begin
    int div = 0;
    bit prev = 1'b0;
    int rx_st = 0;
    int rx_n = 0;
    logic [7:0] rx_b = '0;
    forever begin
      @(negedge clk);
      if (rst) begin
        div = 0; prev = 1'b0; rx_st = 0; baud_tick = 1'b0;
      end else begin
        if (prev) begin
          case (rx_st)
            0: if (tx_out == 1'b0) begin rx_st = 1; rx_n = 0; end
            1: begin
              rx_b[rx_n] = tx_out;
              rx_n++;
              if (rx_n == 8) rx_st = 2;
            end
            default: begin
              chk("R2 stop bit", {7'b0, tx_out}, 8'h01);
              rx_buf[rx_wr % 64] = rx_b;
              rx_wr++;
              rx_st = 0;
            end
          endcase
        end
        if (cmd_err) err_cnt++;
        if (tick_en) begin
          baud_tick = (div == TICK_DIV - 1);
          div = (div == TICK_DIV - 1) ? 0 : div + 1;
        end else begin
          baud_tick = 1'b0;
          div = 0;
        end
        prev = baud_tick;
      end
    end
  end

  task automatic host_write(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    host_wr = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic host_read(input logic [2:0] a, input logic [7:0] e, input string req);
    @(negedge clk);
    host_addr = a;
    @(negedge clk);
    chk(req, host_rdata, e);
  endtask

  task automatic push(input logic [7:0] d);
    @(negedge clk);
    fifo_wr = 1'b1; fifo_wdata = d;
    @(negedge clk);
    fifo_wr = 1'b0;
  endtask

  task automatic expect_byte(input logic [7:0] e, input string req);
    int t = 0;
    while (rx_rd >= rx_wr && t < 2000) begin
      @(negedge clk);
      t++;
    end
    if (rx_rd >= rx_wr) begin
      chk({req, " timeout"}, 8'hXX, e);
    end else begin
      chk(req, rx_buf[rx_rd % 64], e);
      rx_rd++;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (5) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    @(negedge clk);
    chk("R1 tx idle", {7'b0, tx_out}, 8'h01);
    chk("R1 cmd_err", {7'b0, cmd_err}, 8'h00);
    chk("R1 fifo_full", {7'b0, fifo_full}, 8'h00);
    for (int a = 0; a < 6; a++) host_read(3'(a), 8'h00, "R1 register reset");
    tick_en = 1'b1;

    for (int v = 0; v < NV; v++) begin
      logic [2:0] op;
      logic [2:0] ad;
      logic [7:0] dt;
      string tag;
      op = VEC[v][17:15];
      ad = VEC[v][14:12];
      dt = VEC[v][11:4];
      tag = $sformatf("R%0d vec%0d", VEC[v][3:0], v);
      case (op)
        OP_WR:   host_write(ad, dt);
        OP_PUSH: push(dt);
        OP_RD:   host_read(ad, dt, tag);
        OP_EXPB: expect_byte(dt, tag);
        OP_WAIT: repeat (int'(dt)) @(negedge clk);
        OP_ERRC: begin
          repeat (2) @(negedge clk);
          chk(tag, 8'(err_cnt), dt);
        end
        default: ;
      endcase
    end

    // R2 start bit lasts exactly one tick period
    begin
      int t = 0;
      int low = 0;
      push(8'h01);
      while (tx_out !== 1'b0 && t < 500) begin @(negedge clk); t++; end
      while (tx_out === 1'b0 && low < 100) begin @(negedge clk); low++; end
      chk("R2 start bit width", 8'(low), 8'(TICK_DIV));
      expect_byte(8'h01, "R2 LSB first");
    end

    // R3 fill the queue with the line stalled, one extra write dropped
    repeat (3 * TICK_DIV) @(negedge clk);
    tick_en = 1'b0;
    for (int i = 0; i <= DEPTH; i++) push(8'(8'h40 + i));
    chk("R3 fifo_full", {7'b0, fifo_full}, 8'h01);
    tick_en = 1'b1;
    for (int i = 0; i < DEPTH; i++) expect_byte(8'(8'h40 + i), "R3 order");
    push(8'hEE);
    expect_byte(8'hEE, "R3 overflow byte discarded");
    chk("R3 full released", {7'b0, fifo_full}, 8'h00);
    repeat (4 * TICK_DIV) @(negedge clk);
    chk("R2 idle high", {7'b0, tx_out}, 8'h01);

    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule